// File: doc/BRIEF.md
# Chained three-channel DMA controller

This block copies 16-bit words from one memory-mapped location to another on a simple single-master bus. It has three channels. Each channel holds a source base, a destination base, a word count, a mode, per-side address stepping, a trigger source and a half-way interrupt enable. Software arms a channel with a start pulse. From then on every trigger event asks the shared transfer engine for service.

A channel's trigger is either its own external request line or the completion of the channel before it in a fixed ring: 2 feeds 0, 0 feeds 1 and 1 feeds 2. A peripheral such as a converter-ready strobe can therefore start a chain, and the other channels follow with no software in between. Each channel has three sticky flags: one for reaching the end of its count, one for reaching the half-way point and one for a lost trigger. The half-way flag lets a consumer work on one half of a buffer while the other half fills.

Top module: `dma_ring_top`

## Requirements
- R1: After reset `mem_rd`, `mem_wr`, `irq_done`, `irq_half` and `overrun` are all 0, and no channel is armed.
- R2: Each word takes four clock cycles: a read strobe, a cycle that captures `mem_rdata` (the bus returns it one cycle after the read), a write strobe and a bookkeeping cycle. A block of N words started by one trigger sets its done flag N*4+1 rising edges after the edge that samples the trigger.
- R3: In single mode (`cfg_mode` = 2'b00) each trigger moves one word. When the count reaches zero the channel sets its done flag, disarms itself, and ignores all later triggers until it is started again.
- R4: In repeated single mode (`cfg_mode` = 2'b10) the channel reloads its count and both base addresses when the count reaches zero, and it stays armed.
- R5: In block mode (`cfg_mode` bit 0 = 1) one trigger moves all the words that remain. Repeated block mode (2'b11) then reloads and waits for the next trigger.
- R6: An address side whose increment bit is 1 steps by one word after each transfer. A side whose bit is 0 keeps the same address.
- R7: With `cfg_trig_sel[i]` = 1, channel i is triggered by the completion of channel (i+2) mod 3. With 0 it is triggered by `ext_req[i]`, where each cycle the line is high counts as one event.
- R8: With `cfg_half_en[i]` = 1 and a size of 2 or more, the half flag is set by the transfer that leaves size/2 words remaining, and not before.
- R9: A trigger that arrives while a channel is busy is held once as pending and served afterwards. A trigger that arrives while one is already pending is dropped and sets the overrun flag.
- R10: When several channels are pending, the lowest-numbered one is served first. A transfer that has started, including a whole block, is never interrupted by another channel.
- R11: Triggers to a channel that has never been started cause no bus writes.
- R12: `flag_clr[i]` clears all three flags of channel i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ch_start | input | 3 | Arm channel i and load its count and base addresses |
| ext_req | input | 3 | External trigger for each channel, one event per high cycle |
| flag_clr | input | 3 | Clear the flags of channel i |
| cfg_src | input | 3*AW | Source base address for each channel |
| cfg_dst | input | 3*AW | Destination base address for each channel |
| cfg_size | input | 3*CW | Word count for each channel |
| cfg_mode | input | 6 | Two bits per channel: bit 0 selects block, bit 1 selects repeat |
| cfg_src_inc | input | 3 | Source address stepping enable |
| cfg_dst_inc | input | 3 | Destination address stepping enable |
| cfg_trig_sel | input | 3 | 0 selects the external request, 1 selects completion of the previous channel in the ring |
| cfg_half_en | input | 3 | Half-way flag enable |
| mem_rd | output | 1 | Bus read strobe |
| mem_wr | output | 1 | Bus write strobe |
| mem_addr | output | AW | Bus address |
| mem_wdata | output | DW | Bus write data |
| mem_rdata | input | DW | Bus read data, valid the cycle after `mem_rd` |
| irq_done | output | 3 | Sticky count-complete flags |
| irq_half | output | 3 | Sticky half-way flags |
| overrun | output | 3 | Sticky dropped-trigger flags |

## Verification
The hardest situation to reach from the ports is a trigger that lands on the exact cycle the engine takes the channel's pending request, since that event must survive as a fresh pending request. The bench reaches it by holding `ext_req` high for two and then for three consecutive cycles on a repeated block channel. It then counts bus writes and reads the overrun flag. Ring wiring is checked by starting one chain from channel 0 and another from channel 2. Ordering is checked with a write-address log: first with simultaneous triggers, then with a trigger that arrives in the middle of a running block.

// File: rtl/dma_ring_pkg.sv
// Shared constants and engine state type for the chained DMA controller.
package dma_ring_pkg;
    localparam int NCH = 3;
    localparam int SW  = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_WAIT,
        ST_WR,
        ST_DONE
    } eng_st_t;
endpackage

// File: rtl/dma_ring_chan.sv
// One channel: holds arm state, remaining count, current addresses,
// the single pending slot and the sticky flags.
// Assumes step_i pulses only in the bookkeeping cycle of a word moved for
// this channel, and grant_i only when the engine accepts its request.
module dma_ring_chan #(
    parameter int AW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          trig_i,
    input  logic          step_i,
    input  logic          grant_i,
    input  logic          clr_i,
    input  logic [AW-1:0] base_src_i,
    input  logic [AW-1:0] base_dst_i,
    input  logic [CW-1:0] size_i,
    input  logic          rpt_i,
    input  logic          sinc_i,
    input  logic          dinc_i,
    input  logic          half_en_i,
    output logic          req_o,
    output logic          last_o,
    output logic          comp_o,
    output logic [AW-1:0] src_o,
    output logic [AW-1:0] dst_o,
    output logic          done_flag_o,
    output logic          half_flag_o,
    output logic          ovr_flag_o
);
    logic          armed, pend;
    logic [CW-1:0] cnt;
    logic          finish, disarm, half_hit, ovr_hit, live_trig;

    assign last_o    = (cnt == CW'(1));
    assign finish    = step_i && last_o;
    assign disarm    = finish && !rpt_i;
    assign comp_o    = finish;
    assign req_o     = pend && armed && !disarm;
    assign live_trig = trig_i && armed;
    assign ovr_hit   = live_trig && pend && !grant_i;
    assign half_hit  = half_en_i && step_i && (size_i >= CW'(2))
                       && ((cnt - CW'(1)) == (size_i >> 1));

    // Count and address progress, reload or disarm at the end of the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
            cnt   <= '0;
            src_o <= '0;
            dst_o <= '0;
        end else if (start_i) begin
            armed <= (size_i != '0);
            cnt   <= size_i;
            src_o <= base_src_i;
            dst_o <= base_dst_i;
        end else if (step_i) begin
            if (last_o) begin
                if (rpt_i) begin
                    cnt   <= size_i;
                    src_o <= base_src_i;
                    dst_o <= base_dst_i;
                end else begin
                    armed <= 1'b0;
                    cnt   <= '0;
                end
            end else begin
                cnt   <= cnt - CW'(1);
                src_o <= src_o + (sinc_i ? AW'(1) : AW'(0));
                dst_o <= dst_o + (dinc_i ? AW'(1) : AW'(0));
            end
        end
    end

    // Single pending slot: set by a trigger, consumed by a grant.
    always_ff @(posedge clk) begin
        if (!rst_n)          pend <= 1'b0;
        else if (start_i)    pend <= 1'b0;
        else if (disarm)     pend <= 1'b0;
        else if (live_trig)  pend <= 1'b1;
        else if (grant_i)    pend <= 1'b0;
    end

    // Sticky flags; a set in the same cycle wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_flag_o <= 1'b0;
            half_flag_o <= 1'b0;
            ovr_flag_o  <= 1'b0;
        end else begin
            done_flag_o <= finish   || (done_flag_o && !clr_i);
            half_flag_o <= half_hit || (half_flag_o && !clr_i);
            ovr_flag_o  <= ovr_hit  || (ovr_flag_o  && !clr_i);
        end
    end
endmodule

// File: rtl/dma_ring_arb.sv
// Fixed-priority selector: the lowest-numbered requesting channel wins.
// A grant is issued only while the engine can accept a new service.
module dma_ring_arb
    import dma_ring_pkg::*;
(
    input  logic [NCH-1:0] req_i,
    input  logic           take_i,
    output logic [NCH-1:0] grant_o,
    output logic           any_o
);
    // Pick the lowest set request bit.
    always_comb begin
        grant_o = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req_i[i]) grant_o = '0;
            if (req_i[i]) grant_o[i] = take_i;
        end
    end

    assign any_o = |req_i;
endmodule

// File: rtl/dma_ring_engine.sv
// Four-cycle word mover shared by all channels: read, capture, write,
// bookkeeping. In block mode it runs back to back on the same channel.
// Assumes the bus returns read data one cycle after the read strobe.
module dma_ring_engine
    import dma_ring_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           any_req_i,
    input  logic [NCH-1:0] grant_i,
    input  logic           cont_i,
    input  logic [AW-1:0]  src_i,
    input  logic [AW-1:0]  dst_i,
    input  logic [DW-1:0]  mem_rdata,
    output logic           take_o,
    output logic [SW-1:0]  sel_o,
    output logic [NCH-1:0] step_o,
    output logic           mid_o,
    output logic           mem_rd,
    output logic           mem_wr,
    output logic [AW-1:0]  mem_addr,
    output logic [DW-1:0]  mem_wdata
);
    eng_st_t       st;
    logic [DW-1:0] data_q;
    logic [SW-1:0] gidx;

    assign take_o = ((st == ST_IDLE) || ((st == ST_DONE) && !cont_i)) && any_req_i;
    assign mid_o  = (st == ST_RD) || (st == ST_WAIT) || (st == ST_WR);

    // Turn the one-hot grant into a channel index.
    always_comb begin
        gidx = '0;
        for (int i = 0; i < NCH; i++)
            if (grant_i[i]) gidx = SW'(i);
    end

    // Word sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            sel_o  <= '0;
            data_q <= '0;
        end else begin
            case (st)
                ST_IDLE: if (take_o) begin
                    st    <= ST_RD;
                    sel_o <= gidx;
                end
                ST_RD:   st <= ST_WAIT;
                ST_WAIT: begin
                    data_q <= mem_rdata;
                    st     <= ST_WR;
                end
                ST_WR:   st <= ST_DONE;
                ST_DONE: begin
                    if (cont_i) st <= ST_RD;
                    else if (take_o) begin
                        st    <= ST_RD;
                        sel_o <= gidx;
                    end else st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Bus drive and per-channel bookkeeping pulse.
    always_comb begin
        mem_rd    = (st == ST_RD);
        mem_wr    = (st == ST_WR);
        mem_addr  = (st == ST_WR) ? dst_i : src_i;
        mem_wdata = data_q;
        step_o    = '0;
        if (st == ST_DONE) step_o[sel_o] = 1'b1;
    end
endmodule

// File: rtl/dma_ring_top.sv
// Three-channel DMA controller with a fixed completion ring (2->0, 0->1,
// 1->2) and half-way flags. Configuration inputs are read live; software
// holds them steady while a channel is armed.
module dma_ring_top
    import dma_ring_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int CW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    ch_start,
    input  logic [NCH-1:0]    ext_req,
    input  logic [NCH-1:0]    flag_clr,
    input  logic [NCH*AW-1:0] cfg_src,
    input  logic [NCH*AW-1:0] cfg_dst,
    input  logic [NCH*CW-1:0] cfg_size,
    input  logic [2*NCH-1:0]  cfg_mode,
    input  logic [NCH-1:0]    cfg_src_inc,
    input  logic [NCH-1:0]    cfg_dst_inc,
    input  logic [NCH-1:0]    cfg_trig_sel,
    input  logic [NCH-1:0]    cfg_half_en,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [AW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata,
    input  logic [DW-1:0]     mem_rdata,
    output logic [NCH-1:0]    irq_done,
    output logic [NCH-1:0]    irq_half,
    output logic [NCH-1:0]    overrun
);
    logic [NCH-1:0] req, last, comp, step, grant, trig;
    logic [AW-1:0]  src_a [NCH];
    logic [AW-1:0]  dst_a [NCH];
    logic [SW-1:0]  eng_sel;
    logic           eng_mid, take, any_req, cont;
    logic [AW-1:0]  cur_src, cur_dst;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        localparam int PREV = (i + NCH - 1) % NCH;
        assign trig[i] = cfg_trig_sel[i] ? comp[PREV] : ext_req[i];

        dma_ring_chan #(.AW(AW), .CW(CW)) u_chan (
            .clk(clk), .rst_n(rst_n),
            .start_i(ch_start[i]), .trig_i(trig[i]), .step_i(step[i]),
            .grant_i(grant[i]), .clr_i(flag_clr[i]),
            .base_src_i(cfg_src[i*AW +: AW]), .base_dst_i(cfg_dst[i*AW +: AW]),
            .size_i(cfg_size[i*CW +: CW]), .rpt_i(cfg_mode[2*i+1]),
            .sinc_i(cfg_src_inc[i]), .dinc_i(cfg_dst_inc[i]),
            .half_en_i(cfg_half_en[i]),
            .req_o(req[i]), .last_o(last[i]), .comp_o(comp[i]),
            .src_o(src_a[i]), .dst_o(dst_a[i]),
            .done_flag_o(irq_done[i]), .half_flag_o(irq_half[i]),
            .ovr_flag_o(overrun[i])
        );
    end

    // Route the served channel's addresses and block-continuation to the engine.
    always_comb begin
        cur_src = '0;
        cur_dst = '0;
        cont    = 1'b0;
        for (int i = 0; i < NCH; i++) begin
            if (eng_sel == SW'(i)) begin
                cur_src = src_a[i];
                cur_dst = dst_a[i];
                cont    = cfg_mode[2*i] && !last[i];
            end
        end
    end

    dma_ring_arb u_arb (
        .req_i(req), .take_i(take), .grant_o(grant), .any_o(any_req)
    );

    dma_ring_engine #(.AW(AW), .DW(DW)) u_eng (
        .clk(clk), .rst_n(rst_n), .any_req_i(any_req), .grant_i(grant),
        .cont_i(cont), .src_i(cur_src), .dst_i(cur_dst), .mem_rdata(mem_rdata),
        .take_o(take), .sel_o(eng_sel), .step_o(step), .mid_o(eng_mid),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata)
    );
endmodule

// File: rtl/dma_ring_chk.sv
// Protocol checker for dma_ring_top, attached with bind below.
module dma_ring_chk
    import dma_ring_pkg::*;
(
    input logic           clk,
    input logic           rst_n,
    input logic           mem_rd,
    input logic           mem_wr,
    input logic [NCH-1:0] irq_done,
    input logic [NCH-1:0] grant,
    input logic [SW-1:0]  eng_sel,
    input logic           eng_mid
);
    // R2
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R2
    wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> $past(mem_rd, 2));

    // R3
    done_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(irq_done & ~$past(irq_done))) |-> $past(mem_wr, 2));

    // R10
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R10
    no_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_mid |=> $stable(eng_sel));
endmodule

bind dma_ring_top dma_ring_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .irq_done(irq_done), .grant(grant), .eng_sel(eng_sel), .eng_mid(eng_mid)
);

// File: tb/sim_dma_ring_top.sv
module sim_dma_ring_top;
    localparam int AW = 16, DW = 16, CW = 8;

    logic          clk = 0, rst_n = 0;
    logic [2:0]    ch_start = 0, ext_req = 0, flag_clr = 0;
    logic [47:0]   cfg_src = 0, cfg_dst = 0;
    logic [23:0]   cfg_size = 0;
    logic [5:0]    cfg_mode = 0;
    logic [2:0]    cfg_src_inc = 0, cfg_dst_inc = 0, cfg_trig_sel = 0, cfg_half_en = 0;
    logic          mem_rd, mem_wr;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = 0;
    logic [2:0]    irq_done, irq_half, overrun;

    logic [15:0]   mem [256];
    logic [7:0]    wlog [64];
    int            wcnt = 0;
    int            checks = 0, failures = 0;

    always #5 clk = ~clk;

    dma_ring_top #(.AW(AW), .DW(DW), .CW(CW)) u0 (.*);

    // Bus model: registered read, write on the clock edge.
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
        if (mem_wr) begin
            mem[mem_addr[7:0]] <= mem_wdata;
            wlog[wcnt % 64]    <= mem_addr[7:0];
            wcnt               <= wcnt + 1;
        end
    end

    function automatic logic [15:0] f(input int i);
        return 16'h5000 ^ 16'(i * 37);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg(input int ch, input int src, input int dst, input int size,
                       input int mode, input bit si, input bit di, input bit ts, input bit he);
        cfg_src[ch*16 +: 16]  = 16'(src);
        cfg_dst[ch*16 +: 16]  = 16'(dst);
        cfg_size[ch*8 +: 8]   = 8'(size);
        cfg_mode[ch*2 +: 2]   = 2'(mode);
        cfg_src_inc[ch]  = si;
        cfg_dst_inc[ch]  = di;
        cfg_trig_sel[ch] = ts;
        cfg_half_en[ch]  = he;
    endtask

    task automatic pulse_req(input logic [2:0] m, input int n);
        @(negedge clk) ext_req = m;
        repeat (n) @(negedge clk);
        ext_req = 0;
    endtask

    task automatic start(input logic [2:0] m);
        @(negedge clk) ch_start = m;
        @(negedge clk) ch_start = 0;
    endtask

    task automatic clear(input logic [2:0] m);
        @(negedge clk) flag_clr = m;
        @(negedge clk) flag_clr = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int w0, n;
        for (int i = 0; i < 256; i++) mem[i] = f(i);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(mem_rd == 0 && mem_wr == 0, "R1 bus idle", {mem_rd, mem_wr}, 0);
        chk(irq_done == 0 && irq_half == 0 && overrun == 0, "R1 flags",
            {irq_done, irq_half, overrun}, 0);
        rst_n = 1;
        idle(2);

        // R11 unarmed channels ignore triggers
        w0 = wcnt;
        pulse_req(3'b111, 1);
        idle(20);
        chk(wcnt == w0, "R11 no writes", wcnt - w0, 0);

        // R3 single mode, R6 both sides incrementing
        cfg(0, 'h00, 'h80, 4, 0, 1, 1, 0, 0);
        start(3'b001);
        for (int k = 0; k < 4; k++) begin
            pulse_req(3'b001, 1);
            idle(10);
            if (k == 2) chk(irq_done[0] == 0, "R3 no done early", irq_done[0], 0);
        end
        chk(irq_done[0] == 1, "R3 done at zero", irq_done[0], 1);
        for (int k = 0; k < 4; k++)
            chk(mem[8'h80 + k] == f(k), "R6 incrementing copy", mem[8'h80 + k], f(k));
        w0 = wcnt;
        pulse_req(3'b001, 1);
        idle(10);
        chk(wcnt == w0, "R3 disarmed ignores trigger", wcnt - w0, 0);

        // R12 flag clear
        clear(3'b001);
        chk(irq_done[0] == 0, "R12 clear done", irq_done[0], 0);

        // R2 / R5 block of 16 timing
        cfg(1, 'h10, 'h90, 16, 1, 1, 1, 0, 0);
        start(3'b010);
        w0 = wcnt;
        @(negedge clk) ext_req = 3'b010;
        @(posedge clk);
        n = 0;
        @(negedge clk) ext_req = 0;
        while (n < 200) begin
            if (irq_done[1]) break;
            @(posedge clk);
            n++;
            @(negedge clk);
        end
        chk(n == 65, "R2 block completion cycle", n, 65);
        chk(wcnt - w0 == 16, "R5 whole block on one trigger", wcnt - w0, 16);
        for (int k = 0; k < 16; k += 5)
            chk(mem[8'h90 + k] == f(16 + k), "R5 block data", mem[8'h90 + k], f(16 + k));

        // R4 repeated single, R8 half flag, R6 fixed source
        cfg(2, 'h40, 'hA0, 8, 2, 0, 1, 0, 1);
        start(3'b100);
        for (int k = 0; k < 8; k++) begin
            mem[8'h40] = 16'h1100 + 16'(k);
            pulse_req(3'b100, 1);
            idle(10);
            if (k == 2) chk(irq_half[2] == 0, "R8 no half early", irq_half[2], 0);
            if (k == 3) chk(irq_half[2] == 1, "R8 half at size/2", irq_half[2], 1);
            if (k == 6) chk(irq_done[2] == 0, "R4 no done early", irq_done[2], 0);
        end
        chk(irq_done[2] == 1, "R4 done at zero", irq_done[2], 1);
        chk(mem[8'hA5] == 16'h1105, "R6 fixed source", mem[8'hA5], 16'h1105);
        clear(3'b100);
        mem[8'h40] = 16'h7777;
        pulse_req(3'b100, 1);
        idle(10);
        chk(mem[8'hA0] == 16'h7777, "R4 reload and stay armed", mem[8'hA0], 16'h7777);
        chk(mem[8'hA1] == 16'h1101, "R4 reload to base", mem[8'hA1], 16'h1101);
        cfg(2, 'h40, 'hA0, 8, 0, 0, 1, 0, 0);
        start(3'b000);

        // R7 ring 0 -> 1 -> 2
        clear(3'b111);
        cfg(0, 'h00, 'hC0, 4, 1, 1, 1, 0, 0);
        cfg(1, 'h04, 'hC4, 4, 1, 1, 1, 1, 0);
        cfg(2, 'h08, 'hC8, 2, 1, 1, 1, 1, 0);
        start(3'b111);
        w0 = wcnt;
        pulse_req(3'b001, 1);
        idle(100);
        chk(irq_done == 3'b111, "R7 chain 0-1-2 all done", irq_done, 7);
        chk(wcnt - w0 == 10, "R7 chain writes", wcnt - w0, 10);
        chk(mem[8'hC9] == f(9), "R7 tail data", mem[8'hC9], f(9));

        // R7 ring 2 -> 0
        clear(3'b111);
        cfg(0, 'h00, 'hD0, 4, 1, 1, 1, 1, 0);
        cfg(1, 'h04, 'hC4, 4, 1, 1, 1, 0, 0);
        cfg(2, 'h08, 'hD8, 2, 1, 1, 1, 0, 0);
        start(3'b101);
        w0 = wcnt;
        pulse_req(3'b100, 1);
        idle(80);
        chk(irq_done == 3'b101, "R7 chain 2-0", irq_done, 5);
        chk(wcnt - w0 == 6, "R7 chain 2-0 writes", wcnt - w0, 6);
        chk(mem[8'hD3] == f(3), "R7 ch0 data", mem[8'hD3], f(3));

        // R9 pending and overrun on repeated block
        clear(3'b111);
        cfg(0, 'h00, 'hE0, 4, 3, 1, 1, 0, 0);
        start(3'b001);
        w0 = wcnt;
        pulse_req(3'b001, 2);
        idle(60);
        chk(wcnt - w0 == 8, "R9 pending served", wcnt - w0, 8);
        chk(overrun[0] == 0, "R9 no overrun", overrun[0], 0);
        w0 = wcnt;
        pulse_req(3'b001, 3);
        idle(60);
        chk(wcnt - w0 == 8, "R9 extra trigger dropped", wcnt - w0, 8);
        chk(overrun[0] == 1, "R9 overrun set", overrun[0], 1);
        cfg(0, 'h00, 'hE0, 4, 0, 1, 1, 0, 0);
        start(3'b000);

        // R10 priority on simultaneous triggers
        clear(3'b111);
        cfg(0, 'h20, 'hF0, 1, 0, 1, 1, 0, 0);
        cfg(2, 'h22, 'hF2, 1, 0, 1, 1, 0, 0);
        start(3'b101);
        w0 = wcnt;
        pulse_req(3'b101, 1);
        idle(20);
        chk(wlog[w0 % 64] == 8'hF0, "R10 lowest first", wlog[w0 % 64], 'hF0);
        chk(wlog[(w0 + 1) % 64] == 8'hF2, "R10 then next", wlog[(w0 + 1) % 64], 'hF2);

        // R10 no pre-emption of a running block
        cfg(2, 'h22, 'hF4, 4, 1, 1, 1, 0, 0);
        start(3'b101);
        w0 = wcnt;
        pulse_req(3'b100, 1);
        idle(3);
        pulse_req(3'b001, 1);
        idle(60);
        for (int k = 0; k < 4; k++)
            chk(wlog[(w0 + k) % 64] == 8'(8'hF4 + k), "R10 block uninterrupted",
                wlog[(w0 + k) % 64], 'hF4 + k);
        chk(wlog[(w0 + 4) % 64] == 8'hF0, "R10 waiting channel after",
            wlog[(w0 + 4) % 64], 'hF0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule